// File: doc/BRIEF.md
# Programmer-Side Read Protection Gate

This block sits between an external device programmer and a small on-chip program store. It takes one command per cycle from the programmer. The commands are program byte, read byte, blank check, verify byte, read security byte and set security. Each command gets a registered answer one cycle later, made of a done pulse, a pass/fail flag and a read byte. A sticky security flag hides the array from the programmer. Once the flag is set, every array read comes back as zero, and blank check and verify can no longer succeed. The security byte still reports whether the part is locked.

The security byte is not mapped into the array's address range. It can only be reached through the programmer command path while programming mode is active. A separate instruction-fetch port gives the CPU the true stored contents at all times, so locking the part never affects code execution. The model reset stands for a fresh part: it clears the lock and fills the store with the erased value.

Top module: `prog_guard`

## Requirements
- R1: After reset, rsp_done is low, every location holds the erased value 0xFF (seen on the fetch port), the security byte reads 0x00 and blank check passes.
- R2: While unlocked, a program command (op 3'd1) writes cmd_wdata to cmd_addr and answers with pass=1. The new value is visible on the fetch port after the command's clock edge.
- R3: While unlocked, a read command (op 3'd2) answers with the stored byte at cmd_addr and pass=1.
- R4: While locked, a read command answers with rdata 0x00 and pass=1, whatever is stored.
- R5: A security-byte read (op 3'd5) answers 0x00 when unlocked and 0xFF when locked, with pass=1.
- R6: Blank check (op 3'd3) answers pass=1 only if the part is unlocked and every location holds 0xFF. Otherwise it answers pass=0. Its rdata is 0x00.
- R7: Verify (op 3'd4) answers pass=1 only if the part is unlocked and the byte at cmd_addr equals cmd_wdata. While locked it always answers pass=0. Its rdata is 0x00.
- R8: Set security (op 3'd6) answers pass=1 and locks the part. No command unlocks it, and repeating the set keeps it locked. Only reset clears the lock.
- R9: While locked, a program command answers pass=0 and leaves the store unchanged.
- R10: fetch_data always shows the true byte at fetch_addr, whether locked or not.
- R11: A command presented with prog_mode low is ignored. It produces no done pulse, no write and no change of the lock.
- R12: Every accepted command (cmd_valid and prog_mode high at a clock edge) gives rsp_done high for exactly the following cycle. Op codes 3'd0 and 3'd7 are undefined and answer pass=0 with rdata 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (new part) |
| prog_mode | input | 1 | Programming mode enable; commands are ignored while low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Array location for program, read and verify |
| cmd_wdata | input | DATA_W | Byte to program or to compare against |
| rsp_done | output | 1 | One-cycle answer strobe |
| rsp_pass | output | 1 | Command success flag |
| rsp_rdata | output | DATA_W | Read or security byte, zero for other commands |
| fetch_addr | input | ADDR_W | CPU fetch address |
| fetch_data | output | DATA_W | True stored byte at fetch_addr |

## Verification
The hardest case to reach is a locked part whose store still holds non-erased, known data. Only there can masking be told apart from a genuinely blank or zeroed store. The stimulus therefore programs a distinctive pattern and confirms it through reads and verifies first. Only then does it set the lock and repeat the same reads, verifies and blank checks, while the fetch port confirms that the pattern is still stored. A second reset then shows that only a new part clears the lock.

// File: rtl/pg_pkg.sv
// Package: command codes shared by the protection gate and its checker.
// Assumes a 3-bit command field; codes 0 and 7 are left undefined.
package pg_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_READ   = 3'd2,
        OP_BLANK  = 3'd3,
        OP_VERIFY = 3'd4,
        OP_SECRD  = 3'd5,
        OP_SECSET = 3'd6,
        OP_RSVD   = 3'd7
    } pg_op_e;
endpackage

// File: rtl/pg_array.sv
// Module: pg_array
// Small program store model with one programmer port (read/write) and one
// CPU fetch port (read only). Reset loads the erased value (all ones) into
// every location. Also reports whether the entire store is erased.
// Assumes the writer is the only source of change and depth is modest.
module pg_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_data,
    output logic              all_erased
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  loc_erased;

    // Storage update: erase on reset, otherwise accept programmer writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ERASED;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Per-location erased flags, one comparator per word.
    for (genvar g = 0; g < DEPTH; g++) begin : g_erase
        assign loc_erased[g] = (mem[g] == ERASED);
    end

    // Asynchronous reads for both ports and the whole-array reduction.
    always_comb begin
        rd_data    = mem[rd_addr];
        fetch_data = mem[fetch_addr];
        all_erased = &loc_erased;
    end
endmodule

// File: rtl/pg_lock.sv
// Module: pg_lock
// One-way security flag. Set by request, cleared only by reset.
// Assumes set_req is already qualified by programming mode.
module pg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic locked
);
    // Sticky flag: reset clears it, a set request raises it for good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (set_req) begin
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/pg_respond.sv
// Module: pg_respond
// Decodes a programmer command, issues the write and lock strobes, and
// registers the one-cycle answer. All masking under lock happens here, so
// the store itself never sees the security state.
// Assumes cmd_valid is already qualified by programming mode.
module pg_respond
    import pg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_acc,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              arr_erased,
    input  logic              locked,
    output logic              wr_en,
    output logic              set_req,
    output logic              rsp_done,
    output logic              rsp_pass,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam logic [DATA_W-1:0] SEC_ON  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] SEC_OFF = {DATA_W{1'b0}};

    logic              nxt_pass;
    logic [DATA_W-1:0] nxt_rdata;
    pg_op_e            op;

    assign op = pg_op_e'(cmd_op);

    // Command decode: side-effect strobes plus next answer values.
    always_comb begin
        wr_en     = 1'b0;
        set_req   = 1'b0;
        nxt_pass  = 1'b0;
        nxt_rdata = '0;
        if (cmd_acc) begin
            unique case (op)
                OP_PROG: begin
                    wr_en    = !locked;
                    nxt_pass = !locked;
                end
                OP_READ: begin
                    nxt_pass  = 1'b1;
                    nxt_rdata = locked ? '0 : arr_rdata;
                end
                OP_BLANK: begin
                    nxt_pass = !locked && arr_erased;
                end
                OP_VERIFY: begin
                    nxt_pass = !locked && (arr_rdata == cmd_wdata);
                end
                OP_SECRD: begin
                    nxt_pass  = 1'b1;
                    nxt_rdata = locked ? SEC_ON : SEC_OFF;
                end
                OP_SECSET: begin
                    set_req  = 1'b1;
                    nxt_pass = 1'b1;
                end
                default: begin
                    nxt_pass  = 1'b0;
                    nxt_rdata = '0;
                end
            endcase
        end
    end

    // Answer register: one done pulse per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_pass  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done  <= cmd_acc;
            rsp_pass  <= nxt_pass;
            rsp_rdata <= nxt_rdata;
        end
    end
endmodule

// File: rtl/prog_guard.sv
// Module: prog_guard (top)
// Programming-mode access controller with a one-way read protection flag.
// Commands are accepted only while prog_mode is high; the CPU fetch port
// bypasses all protection. Assumes one command per cycle at most.
module prog_guard #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic              rsp_pass,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_data
);
    logic              cmd_acc;
    logic              wr_en;
    logic              set_req;
    logic              locked;
    logic              arr_erased;
    logic [DATA_W-1:0] arr_rdata;

    // Acceptance: programmer commands count only in programming mode.
    assign cmd_acc = cmd_valid && prog_mode;

    pg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (cmd_addr),
        .wr_data    (cmd_wdata),
        .rd_addr    (cmd_addr),
        .rd_data    (arr_rdata),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data),
        .all_erased (arr_erased)
    );

    pg_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .locked  (locked)
    );

    pg_respond #(.DATA_W(DATA_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_acc    (cmd_acc),
        .cmd_op     (cmd_op),
        .cmd_wdata  (cmd_wdata),
        .arr_rdata  (arr_rdata),
        .arr_erased (arr_erased),
        .locked     (locked),
        .wr_en      (wr_en),
        .set_req    (set_req),
        .rsp_done   (rsp_done),
        .rsp_pass   (rsp_pass),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: rtl/prog_guard_chk.sv
// Module: prog_guard_chk
// Temporal checks on the protection gate, bound into prog_guard.
// Assumes the lock flag of the top is reachable as a bound signal.
module prog_guard_chk
    import pg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_mode,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              rsp_done,
    input logic              rsp_pass,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              locked
);
    logic acc;
    assign acc = cmd_valid && prog_mode;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R8
    AST_LOCK_ONLY_BY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !(acc && cmd_op == OP_SECSET)) |=> !locked); // R8
    AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_READ && locked) |=> (rsp_rdata == '0)); // R4
    AST_SECBYTE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_SECRD) |=>
            (rsp_rdata == ($past(locked) ? {DATA_W{1'b1}} : {DATA_W{1'b0}}))); // R5
    AST_BLANK_LOCKED_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_BLANK && locked) |=> !rsp_pass); // R6
    AST_VERIFY_LOCKED_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_VERIFY && locked) |=> !rsp_pass); // R7
    AST_PROG_LOCKED_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_PROG && locked) |=> !rsp_pass); // R9
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_done); // R11
    AST_ACC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_done); // R12
endmodule

bind prog_guard prog_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_mode (prog_mode),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_done  (rsp_done),
    .rsp_pass  (rsp_pass),
    .rsp_rdata (rsp_rdata),
    .locked    (locked)
);

// File: tb/prog_guard_bench.sv
// Scoreboard bench: issue() predicts each answer from a bench-side model and
// queues it; the monitor pops and compares whenever rsp_done is seen.
module prog_guard_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_mode = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_done;
    logic          rsp_pass;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] fetch_addr = '0;
    logic [DW-1:0] fetch_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit        q_pass [$];
    logic [7:0] q_data [$];
    string     q_tag  [$];

    logic [7:0] m_mem [DEPTH];
    bit         m_sec;

    always #4 clk = ~clk; // 125 MHz

    prog_guard #(.ADDR_W(AW), .DATA_W(DW)) u_prog_guard (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_pass(rsp_pass), .rsp_rdata(rsp_rdata),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    // Monitor: compare every done pulse against the oldest prediction.
    always @(posedge clk) begin
        #2;
        if (rst_n && rsp_done) begin
            total++;
            if (q_pass.size() == 0) begin
                bad++;
                $display("FAIL R11/R12 unexpected done actual=1 expected=0");
            end else begin
                automatic bit ep = q_pass.pop_front();
                automatic logic [7:0] ed = q_data.pop_front();
                automatic string tg = q_tag.pop_front();
                if (rsp_pass !== ep || rsp_rdata !== ed) begin
                    bad++;
                    $display("FAIL %s actual pass=%0b rdata=%h expected pass=%0b rdata=%h",
                             tg, rsp_pass, rsp_rdata, ep, ed);
                end
            end
        end
    end

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        m_sec = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Driver: present one command and queue its predicted answer.
    task automatic issue(input logic [2:0] op, input int a, input logic [7:0] d,
                         input bit pm, input string tag);
        bit ep;
        logic [7:0] ed;
        bit blank;
        @(negedge clk);
        prog_mode = pm;
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_addr = AW'(a);
        cmd_wdata = d;
        if (pm) begin
            ep = 0;
            ed = 8'h00;
            case (op)
                3'd1: begin ep = !m_sec; if (!m_sec) m_mem[a] = d; end
                3'd2: begin ep = 1; ed = m_sec ? 8'h00 : m_mem[a]; end
                3'd3: begin
                    blank = 1;
                    for (int i = 0; i < DEPTH; i++) if (m_mem[i] != 8'hFF) blank = 0;
                    ep = !m_sec && blank;
                end
                3'd4: ep = !m_sec && (m_mem[a] == d);
                3'd5: begin ep = 1; ed = m_sec ? 8'hFF : 8'h00; end
                3'd6: begin ep = 1; m_sec = 1; end
                default: begin ep = 0; ed = 8'h00; end
            endcase
            q_pass.push_back(ep);
            q_data.push_back(ed);
            q_tag.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            prog_mode = 1'b1;
        end
    endtask

    task automatic check_fetch(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        fetch_addr = AW'(a);
        #1;
        total++;
        if (fetch_data !== exp) begin
            bad++;
            $display("FAIL %s fetch[%0d] actual=%h expected=%h", tag, a, fetch_data, exp);
        end
    endtask

    initial begin
        model_reset();
        do_reset();
        idle(1);
        total++;
        if (rsp_done !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset done actual=%b expected=0", rsp_done);
        end
        for (int i = 0; i < DEPTH; i++) check_fetch(i, 8'hFF, "R1 erased");
        issue(3'd5, 0, 0, 1, "R1/R5 secbyte unlocked");
        issue(3'd3, 0, 0, 1, "R1/R6 blank after reset");
        idle(2);

        issue(3'd1, 3, 8'h5A, 1, "R2 program");
        idle(1);
        check_fetch(3, 8'h5A, "R2 fetch after program");
        issue(3'd2, 3, 0, 1, "R3 read back");
        issue(3'd3, 0, 0, 1, "R6 blank fails on data");
        issue(3'd4, 3, 8'h5A, 1, "R7 verify match");
        issue(3'd4, 3, 8'h5B, 1, "R7 verify mismatch");
        for (int i = 8; i < 12; i++) issue(3'd1, i, 8'(i * 17), 1, "R2 program pattern");
        for (int i = 8; i < 12; i++) issue(3'd2, i, 0, 1, "R3 read pattern");
        issue(3'd1, 0, 8'h00, 1, "R2 program zero");
        issue(3'd2, 0, 0, 1, "R3 read zero");
        idle(2);

        issue(3'd1, 7, 8'h00, 0, "R11 program ignored");
        issue(3'd6, 0, 0, 0, "R11 set ignored");
        idle(2);
        check_fetch(7, 8'hFF, "R11 no write");
        issue(3'd5, 0, 0, 1, "R11 lock unchanged");
        issue(3'd0, 2, 8'h33, 1, "R12 undefined op 0");
        issue(3'd7, 2, 8'h33, 1, "R12 undefined op 7");
        idle(2);

        issue(3'd6, 0, 0, 1, "R8 set security");
        issue(3'd5, 0, 0, 1, "R5 secbyte locked");
        issue(3'd2, 3, 0, 1, "R4 read masked");
        issue(3'd2, 9, 0, 1, "R4 read masked pattern");
        issue(3'd3, 0, 0, 1, "R6 blank fails locked");
        issue(3'd4, 3, 8'h5A, 1, "R7 verify fails locked");
        issue(3'd4, 5, 8'hFF, 1, "R7 verify erased fails locked");
        issue(3'd1, 3, 8'h11, 1, "R9 program rejected");
        idle(2);
        check_fetch(3, 8'h5A, "R9/R10 store kept");
        check_fetch(9, 8'd153, "R10 fetch locked");
        for (int op = 0; op < 8; op++) issue(3'(op), 1, 8'h00, 1, "R8 all ops");
        issue(3'd5, 0, 0, 1, "R8 still locked");
        idle(2);

        do_reset();
        issue(3'd5, 0, 0, 1, "R8 reset clears lock");
        issue(3'd3, 0, 0, 1, "R8/R6 blank after new part");
        issue(3'd2, 3, 0, 1, "R3 read erased");
        idle(3);

        total++;
        if (q_pass.size() != 0) begin
            bad++;
            $display("FAIL R12 missing done actual=%0d expected=0", q_pass.size());
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule